// File: doc/BRIEF.md
# Asynchronous ROM Read Timing Controller

This block sits between a synchronous host and an asynchronous parallel ROM. The host hands over one read at a time on a valid/ready handshake. The request carries a word address, a width select and, for byte reads, a half select. The controller drives the ROM address, width-select, chip-enable and output-enable pins in a timed sequence. It captures the returned data on the last wait cycle and returns it with a one-cycle valid pulse. When the access ends, both enables go high, so the device drops back to standby.

Every analog delay is a parameter in nanoseconds: address access, output-enable access, output float and upper-lane float. Each is turned into a cycle count from the clock-period parameter. The count is the ceiling of delay over period, never less than one.

Output enable is held back after chip enable by the difference between the address-access count and the output-enable count. Because of this, data is due on the same cycle however the two enables are ordered. When a request changes the word/byte setting, a settle phase runs first with chip enable high. It lasts the address-access count when moving to word width, and the upper-float count when moving to byte width. After each access, a bus-free output stays low for the float count before a new request is taken.

Top module: `rom_rd_ctrl`

## Requirements
- R1: While reset is applied and directly after it, rom_ce_n and rom_oe_n are 1, rom_byte_n is 1 (word width), req_ready and bus_free are 1, and rsp_valid is 0.
- R2: In a read with no width change, rsp_valid is 1 for exactly one cycle, starting NA cycles after the accepting clock edge. NA is max(1, ceil(T_ACC_NS/CLK_NS)), which is 5 at default. rsp_data then holds the ROM data sampled at the end of the last wait cycle.
- R3: rom_ce_n is 0 for exactly NA cycles after the accepting edge. rom_oe_n is 0 only during the last NO cycles of that window, where NO = max(1, ceil(T_OE_NS/CLK_NS)), which is 3 at default. Both are 1 at every other time.
- R4: A request with req_byte=1 drives rom_byte_n=0 and rom_a_lsb=req_hi. It returns rsp_data = {8'h00, rom_dq[7:0]}. A request with req_byte=0 drives rom_byte_n=1 and rom_a_lsb=0, and returns all 16 bits of rom_dq.
- R5: When req_byte differs from the current width, a settle phase with rom_ce_n=1 comes before chip enable. It lasts NA cycles on a change to word width, and NB = max(1, ceil(T_BFLT_NS/CLK_NS)) cycles (3 at default) on a change to byte width. This delays rsp_valid and the rest of the sequence by the same number of cycles.
- R6: bus_free is 0 from the accepting edge until NF = max(1, ceil(T_FLT_NS/CLK_NS)) cycles (3 at default) after chip enable rises, except during a settle phase. req_ready returns to 1 only together with bus_free, so the next request is accepted no earlier than that.
- R7: rom_addr, rom_a_lsb and rom_byte_n do not change from the accepting edge until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host read request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | ADDR_W | Word address of the read |
| req_byte | input | 1 | 1 selects byte width, 0 word width |
| req_hi | input | 1 | In byte width, 1 selects the upper byte |
| rsp_valid | output | 1 | One-cycle pulse marking rsp_data |
| rsp_data | output | DATA_W | Captured read data |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_byte_n | output | 1 | ROM width select, 1 = word, 0 = byte |
| rom_a_lsb | output | 1 | Extra low address bit used in byte width |
| rom_addr | output | ADDR_W | ROM word address |
| rom_dq | input | DATA_W | ROM data lines |
| bus_free | output | 1 | ROM outputs are known to have floated |

## Verification
Counting from the accepting edge, the bench expects the following, where S is the settle count (zero, NA or NB):
- chip enable low over cycles S+1 to S+NA;
- output enable low over the last NO of those cycles;
- rsp_valid in cycle S+NA+1 only;
- bus_free and req_ready back in cycle S+NA+NF+1.

It samples every one of these cycles at the falling clock edge and compares each pin against the value expected for that cycle index. The ROM model in the bench returns garbage until the chip-enable, output-enable, address and width times have run out. The bench tracks these times in nanoseconds from the pin edges, so a capture made early shows up as a data mismatch. A separate monitor checks that bus_free never rises sooner than the float time after chip enable goes high.

// File: rtl/rom_rd_pkg.sv
`timescale 1ns/100ps
package rom_rd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_SETTLE = 3'd1,
      ST_LEAD   = 3'd2,
      ST_OEW    = 3'd3,
      ST_FLOAT  = 3'd4
   } rd_state_e;

   // wait cycles for a delay: ceiling of ns/period, at least one
   function automatic int ns2cyc(input int ns, input int period);
      int c;
      c = (ns + period - 1) / period;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/rom_rd_timer.sv
`timescale 1ns/100ps
module rom_rd_timer #(
   parameter int CW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          done
);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);

   // a new wait may only start once the previous one has run out
   assert_load_on_expiry_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> done);

endmodule

// File: rtl/rom_rd_fsm.sv
`timescale 1ns/100ps
module rom_rd_fsm
   import rom_rd_pkg::*;
#(
   parameter int N_ACC  = 5,
   parameter int N_OE   = 3,
   parameter int N_FLT  = 3,
   parameter int N_BFLT = 3,
   parameter int CW     = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fire,
   input  logic          width_chg,
   input  logic          to_word,
   input  logic          tmr_done,
   output rd_state_e     st,
   output logic          tmr_load,
   output logic [CW-1:0] tmr_val,
   output logic          cap_stb
);

   localparam int N_LEAD = (N_ACC > N_OE) ? (N_ACC - N_OE) : 0;

   rd_state_e     first_st;
   logic [CW-1:0] first_val;
   rd_state_e     nxt;

   // pick the first access phase: a chip-enable-only lead, or straight to output enable
   generate
      if (N_LEAD > 0) begin : g_lead
         assign first_st  = ST_LEAD;
         assign first_val = CW'(N_LEAD - 1);
      end else begin : g_nolead
         assign first_st  = ST_OEW;
         assign first_val = CW'(N_OE - 1);
      end
   endgenerate

   always_comb begin
      nxt      = st;
      tmr_load = 1'b0;
      tmr_val  = '0;
      cap_stb  = 1'b0;
      case (st)
         ST_IDLE: begin
            if (fire) begin
               tmr_load = 1'b1;
               if (width_chg) begin
                  nxt     = ST_SETTLE;
                  tmr_val = to_word ? CW'(N_ACC - 1) : CW'(N_BFLT - 1);
               end else begin
                  nxt     = first_st;
                  tmr_val = first_val;
               end
            end
         end
         ST_SETTLE: begin
            if (tmr_done) begin
               nxt      = first_st;
               tmr_load = 1'b1;
               tmr_val  = first_val;
            end
         end
         ST_LEAD: begin
            if (tmr_done) begin
               nxt      = ST_OEW;
               tmr_load = 1'b1;
               tmr_val  = CW'(N_OE - 1);
            end
         end
         ST_OEW: begin
            if (tmr_done) begin
               nxt      = ST_FLOAT;
               tmr_load = 1'b1;
               tmr_val  = CW'(N_FLT - 1);
               cap_stb  = 1'b1;
            end
         end
         ST_FLOAT: begin
            if (tmr_done)
               nxt = ST_IDLE;
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         st <= ST_IDLE;
      else
         st <= nxt;
   end

   // capture only ever closes an output-enable phase, and the bus then floats
   assert_capture_then_float_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cap_stb |=> (st == ST_FLOAT));

endmodule

// File: rtl/rom_rd_capture.sv
`timescale 1ns/100ps
module rom_rd_capture #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stb,
   input  logic              byte_mode,
   input  logic [DATA_W-1:0] dq,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data
);

   localparam int HALF = DATA_W / 2;

   logic [DATA_W-1:0] shaped;

   // byte width: only the lower lane carries data, the upper lane is floating
   genvar gi;
   generate
      for (gi = 0; gi < DATA_W; gi++) begin : g_lane
         if (gi < HALF) begin : g_lo
            assign shaped[gi] = dq[gi];
         end else begin : g_hi
            assign shaped[gi] = dq[gi] & ~byte_mode;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= stb;
         if (stb)
            rsp_data <= shaped;
      end
   end

   assert_rsp_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   assert_byte_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && byte_mode) |=> (rsp_data[DATA_W-1:HALF] == '0));

endmodule

// File: rtl/rom_rd_ctrl.sv
`timescale 1ns/100ps
module rom_rd_ctrl
   import rom_rd_pkg::*;
#(
   parameter int ADDR_W    = 19,
   parameter int DATA_W    = 16,
   parameter int CLK_NS    = 10,
   parameter int T_ACC_NS  = 50,
   parameter int T_OE_NS   = 30,
   parameter int T_FLT_NS  = 30,
   parameter int T_BFLT_NS = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_byte,
   input  logic              req_hi,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rom_ce_n,
   output logic              rom_oe_n,
   output logic              rom_byte_n,
   output logic              rom_a_lsb,
   output logic [ADDR_W-1:0] rom_addr,
   input  logic [DATA_W-1:0] rom_dq,
   output logic              bus_free
);

   localparam int N_ACC  = ns2cyc(T_ACC_NS, CLK_NS);
   localparam int N_OE   = ns2cyc(T_OE_NS, CLK_NS);
   localparam int N_FLT  = ns2cyc(T_FLT_NS, CLK_NS);
   localparam int N_BFLT = ns2cyc(T_BFLT_NS, CLK_NS);
   localparam int N_MAX  = imax(imax(N_ACC, N_OE), imax(N_FLT, N_BFLT));
   localparam int CW     = $clog2(N_MAX + 1);

   generate
      if (CLK_NS < 1) begin : g_bad_clk
         $error("clock period must be at least 1 ns");
      end
      if ((DATA_W < 2) || (DATA_W % 2 != 0)) begin : g_bad_data
         $error("data width must be even and at least 2");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("address width must be at least 1");
      end
   endgenerate

   rd_state_e     st;
   logic          fire;
   logic          width_chg;
   logic          tmr_load;
   logic [CW-1:0] tmr_val;
   logic          tmr_done;
   logic          cap_stb;

   assign req_ready = (st == ST_IDLE);
   assign fire      = req_valid && req_ready;
   // rom_byte_n high means word width now; a byte request then changes it
   assign width_chg = (req_byte == rom_byte_n);

   rom_rd_fsm #(
      .N_ACC (N_ACC),
      .N_OE  (N_OE),
      .N_FLT (N_FLT),
      .N_BFLT(N_BFLT),
      .CW    (CW)
   ) fsm_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (fire),
      .width_chg(width_chg),
      .to_word  (!req_byte),
      .tmr_done (tmr_done),
      .st       (st),
      .tmr_load (tmr_load),
      .tmr_val  (tmr_val),
      .cap_stb  (cap_stb)
   );

   rom_rd_timer #(
      .CW(CW)
   ) tmr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .load_val(tmr_val),
      .done    (tmr_done)
   );

   rom_rd_capture #(
      .DATA_W(DATA_W)
   ) cap_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .stb      (cap_stb),
      .byte_mode(!rom_byte_n),
      .dq       (rom_dq),
      .rsp_valid(rsp_valid),
      .rsp_data (rsp_data)
   );

   // address side: loaded at acceptance, held until the next one
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rom_addr   <= '0;
         rom_byte_n <= 1'b1;
         rom_a_lsb  <= 1'b0;
      end else if (fire) begin
         rom_addr   <= req_addr;
         rom_byte_n <= !req_byte;
         rom_a_lsb  <= req_byte & req_hi;
      end
   end

   assign rom_ce_n = !((st == ST_LEAD) || (st == ST_OEW));
   assign rom_oe_n = !(st == ST_OEW);
   assign bus_free = (st == ST_IDLE) || (st == ST_SETTLE);

   assert_oe_inside_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !rom_oe_n |-> !rom_ce_n);

   assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |=> ($stable(rom_addr) && $stable(rom_a_lsb) && $stable(rom_byte_n)));

   assert_release_not_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rom_ce_n) |-> !bus_free);

   assert_word_lsb_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rom_byte_n |-> !rom_a_lsb);

   assert_data_after_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rsp_valid) |-> $past(!rom_oe_n));

   assert_no_width_change_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!rom_ce_n && $past(!rom_ce_n)) |-> $stable(rom_byte_n));

endmodule

// File: tb/rom_rd_ctrl_tb_top.sv
`timescale 1ns/100ps
module rom_rd_ctrl_tb_top;

   localparam int CLK_NS = 10;
   localparam int T_ACC  = 50;
   localparam int T_OE   = 30;
   localparam int T_FLT  = 30;
   localparam int T_BFLT = 30;

   function automatic int cyc(input int ns);
      int c;
      c = (ns + CLK_NS - 1) / CLK_NS;
      return (c < 1) ? 1 : c;
   endfunction

   localparam int B_ACC  = cyc(T_ACC);
   localparam int B_OE   = cyc(T_OE);
   localparam int B_FLT  = cyc(T_FLT);
   localparam int B_BFLT = cyc(T_BFLT);
   localparam int B_LEAD = (B_ACC > B_OE) ? B_ACC - B_OE : 0;
   localparam int B_TOT  = B_LEAD + B_OE;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [18:0] req_addr = '0;
   logic        req_byte = 1'b0;
   logic        req_hi = 1'b0;
   logic        rsp_valid;
   logic [15:0] rsp_data;
   logic        rom_ce_n, rom_oe_n, rom_byte_n, rom_a_lsb;
   logic [18:0] rom_addr;
   logic [15:0] rom_dq = '0;
   logic        bus_free;

   int checks = 0;
   int errors = 0;
   int float_viol = 0;
   bit cur_word = 1'b1;

   always #(CLK_NS/2) clk = ~clk;

   rom_rd_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_byte(req_byte), .req_hi(req_hi),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rom_ce_n(rom_ce_n),
      .rom_oe_n(rom_oe_n), .rom_byte_n(rom_byte_n), .rom_a_lsb(rom_a_lsb),
      .rom_addr(rom_addr), .rom_dq(rom_dq), .bus_free(bus_free)
   );

   function automatic logic [15:0] rom_word(input logic [18:0] a);
      logic [15:0] m;
      m = a[15:0] * 16'h9E37;
      return m ^ {a[18:16], 13'h0A5C};
   endfunction

   function automatic logic [15:0] exp_data(input logic [18:0] a, input logic bm, input logic hi);
      logic [15:0] w;
      w = rom_word(a);
      if (!bm) return w;
      return {8'h00, hi ? w[15:8] : w[7:0]};
   endfunction

   // timing-aware ROM model: garbage until every access time has elapsed
   realtime t_ce = 0, t_oe = 0, t_addr = 0, t_byte = 0, t_rel = 0;
   bit released = 1'b0;
   always @(negedge rom_ce_n) t_ce = $realtime;
   always @(negedge rom_oe_n) t_oe = $realtime;
   always @(rom_addr or rom_a_lsb) t_addr = $realtime;
   always @(rom_byte_n) t_byte = $realtime;
   always @(posedge rom_ce_n) begin t_rel = $realtime; released = 1'b1; end

   initial begin
      #0.25;
      forever begin
         realtime now;
         logic ok;
         logic [15:0] w;
         #0.5;
         now = $realtime;
         ok = !rom_ce_n && !rom_oe_n &&
              (now - t_ce >= T_ACC - 1) && (now - t_oe >= T_OE - 1) &&
              (now - t_addr >= T_ACC - 1) && (now - t_byte >= T_ACC - 1);
         w = rom_word(rom_addr);
         if (rom_byte_n)
            rom_dq = ok ? w : 16'hDEAD;
         else
            rom_dq = {8'h5A, ok ? (rom_a_lsb ? w[15:8] : w[7:0]) : 8'hEE};
      end
   end

   // R6 monitor: bus_free must not rise before the float time has passed
   always @(negedge clk) begin
      if (rst_n && bus_free && released && ($realtime - t_rel < T_FLT - 1))
         float_viol++;
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   task automatic do_read(input logic [18:0] a, input logic bm, input logic hi);
      bit chg;
      int s, total, rsp_at, rdy_at;
      int bad_phase, bad_free, bad_rdy, bad_addr, bad_lsb;
      logic [15:0] got;
      chg = bm ? cur_word : !cur_word;
      s = chg ? (bm ? B_BFLT : B_ACC) : 0;
      total = s + B_TOT + B_FLT + 1;
      bad_phase = 0; bad_free = 0; bad_rdy = 0; bad_addr = 0; bad_lsb = 0;
      rsp_at = -1; rdy_at = -1; got = '0;
      req_addr = a; req_byte = bm; req_hi = hi; req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      for (int k = 1; k <= total; k++) begin
         logic e_ce, e_oe, e_free;
         @(negedge clk);
         if (k == 1) req_valid = 1'b0;
         e_ce = !((k > s) && (k <= s + B_TOT));
         e_oe = !((k > s + B_LEAD) && (k <= s + B_TOT));
         e_free = (k <= s) || (k == total);
         if (rom_ce_n !== e_ce || rom_oe_n !== e_oe) bad_phase++;
         if (bus_free !== e_free) bad_free++;
         if (req_ready !== (k == total)) bad_rdy++;
         if (rom_addr !== a || rom_byte_n !== !bm) bad_addr++;
         if (rom_a_lsb !== (bm & hi)) bad_lsb++;
         if (rsp_valid) begin
            if (rsp_at < 0) begin rsp_at = k; got = rsp_data; end
            else rsp_at = 1000;
         end
      end
      cur_word = !bm;
      chk(rsp_at == s + B_TOT + 1, chg ? "R5" : "R2", "rsp_valid cycle", rsp_at, s + B_TOT + 1);
      chk(got === exp_data(a, bm, hi), bm ? "R4" : "R2", "rsp_data", got, exp_data(a, bm, hi));
      chk(bad_phase == 0, "R3", "ce/oe phase mismatches", bad_phase, 0);
      chk(bad_free == 0 && bad_rdy == 0, "R6", "bus_free/ready mismatches", bad_free + bad_rdy, 0);
      chk(bad_addr == 0, "R7", "address/width hold mismatches", bad_addr, 0);
      chk(bad_lsb == 0, "R4", "lsb select mismatches", bad_lsb, 0);
   endtask

   initial begin
      #(CLK_NS * 200000);
      errors++;
      $display("FAIL R6 watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      // R1 during reset
      chk(rom_ce_n === 1'b1 && rom_oe_n === 1'b1, "R1", "enables in reset", {rom_ce_n, rom_oe_n}, 2'b11);
      chk(rsp_valid === 1'b0 && rom_byte_n === 1'b1, "R1", "valid/width in reset", {rsp_valid, rom_byte_n}, 2'b01);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready === 1'b1 && bus_free === 1'b1, "R1", "ready/free after reset", {req_ready, bus_free}, 2'b11);

      // directed corners
      do_read(19'h00000, 1'b0, 1'b0);          // word, no width change (R2)
      do_read(19'h7FFFF, 1'b0, 1'b1);          // top address, req_hi ignored in word width (R4)
      do_read(19'h12345, 1'b1, 1'b0);          // change to byte, lower lane (R5)
      do_read(19'h12345, 1'b1, 1'b1);          // same address, upper lane (R4)
      do_read(19'h0ABCD, 1'b0, 1'b0);          // change back to word (R5)
      do_read(19'h0ABCE, 1'b0, 1'b0);          // back-to-back word

      // random mix
      for (int i = 0; i < 40; i++) begin
         logic [18:0] a;
         logic bm, hi;
         a = 19'($urandom);
         bm = 1'($urandom);
         hi = 1'($urandom);
         do_read(a, bm, hi);
         repeat ($urandom % 3) @(negedge clk);
      end

      chk(float_viol == 0, "R6", "bus_free rose inside float time", float_viol, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule